// File: doc/BRIEF.md
# UART Receive Character Buffer with Trigger Interrupt

This block sits between a UART receiver and the CPU-facing register block. It holds received characters, and break indications, in a small circular store. The CPU pulls them out by reading the data register. The store is tracked by a read pointer and an occupancy count. The write slot is the read pointer plus the count, modulo the depth. The oldest entry is always visible on the read-data output.

A mode input selects the capacity. When the mode input is high, the block is a full-depth FIFO. When it is low, it holds only one character. The block reports whether it can accept a new entry, and it keeps registered empty and full flags. It also keeps a raw receive interrupt request. The request rises when a push brings the count up to the trigger level. It falls when a pop brings the count to one below that level.

Each stored entry is 11 bits wide. A character occupies bits 7:0, with bits 10:8 zero. A break event stores the value 0x400, which is bit 10 set and all other bits zero.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the block shows empty_o=1, full_o=0, rx_irq_o=0 and rd_data_o=0. With fifo_en_i=1, ready_o=1.
- R2: With fifo_en_i=1, ready_o stays high while fewer than DEPTH (16) entries are held. Entries come out in arrival order, and rd_data_o shows the oldest held entry.
- R3: With fifo_en_i=0, ready_o is high only while no entry is held, so at most one character is accepted.
- R4: An accepted push clears empty_o on the next cycle. A pop that leaves zero entries sets empty_o.
- R5: full_o is set after a push that brings the count to DEPTH. In single-character mode, full_o is set after any accepted push. A pop that leaves fewer entries clears full_o.
- R6: A pop while empty leaves rd_data_o, the count and all flags unchanged.
- R7: A push (push_i or brk_i) while ready_o is low is dropped. It changes neither the stored entries nor any flag.
- R8: A pulse on brk_i stores the entry 0x400 (bit 10 set, bits 9:0 zero). A character push stores {3'b000, data_i}. When brk_i and push_i are both high, only the break entry is stored.
- R9: rx_irq_o is set after an accepted push, with no pop in that cycle, that makes the count equal TRIG (default 1). It is cleared after a pop, with no push in that cycle, that makes the count equal TRIG-1. Otherwise it holds.
- R10: An accepted push and a non-empty pop in the same cycle are both performed. The head leaves, the new entry joins the tail, and the count and flags stay the same.
- R11: The read pointer wraps from DEPTH-1 to 0, and order is preserved across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | 1: full-depth buffer, 0: single-character holding |
| push_i | input | 1 | Receiver delivers a character this cycle |
| data_i | input | 8 | Received character |
| brk_i | input | 1 | Receiver signals a break this cycle |
| pop_i | input | 1 | CPU reads the data register this cycle |
| rd_data_o | output | 11 | Entry at the read pointer (break flag in bit 10) |
| ready_o | output | 1 | A push this cycle would be accepted |
| empty_o | output | 1 | Registered empty flag |
| full_o | output | 1 | Registered full flag |
| rx_irq_o | output | 1 | Raw receive interrupt request |

## Verification
The bench targets the following corner cases:

- Overfilling in both modes. A design that miscounts would accept a 17th entry, or a second single-mode character, and overwrite the head.
- Popping while empty. A faulty design would advance the pointer, and the next character would then appear one slot off.
- A simultaneous push and pop at full and near full. Here a wrong ready decision, or count arithmetic, shows up as a lost or duplicated entry.
- A break coinciding with a character, which a wrong design would store with the data byte mixed into it.
- Long pseudo-random traffic that wraps the pointer many times. This exposes any wrap arithmetic error or any stale interrupt level.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = 11;
  localparam int BRK_BIT = ENTRY_W - 1;

  typedef logic [ENTRY_W-1:0] rx_entry_t;

  function automatic rx_entry_t make_entry(input logic brk, input logic [DATA_W-1:0] d);
    rx_entry_t e;
    e = '0;
    if (brk) e[BRK_BIT] = 1'b1;
    else     e[DATA_W-1:0] = d;
    return e;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  rx_entry_t     wdata_i,
  input  logic [AW-1:0] raddr_i,
  output rx_entry_t     rdata_o
);
  rx_entry_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))       mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  AST_STORE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i)); // R2
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          push_req_i,
  input  logic          pop_i,
  output logic          ready_o,
  output logic          push_o,
  output logic          pop_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [AW-1:0] rd_ptr_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // single-character mode accepts only into an empty store
  assign ready_o = fifo_en_i ? (cnt_q < DEPTH_C) : (cnt_q == '0);
  assign push_o  = push_req_i & ready_o;
  assign pop_o   = pop_i & (cnt_q != '0);

  always_comb begin
    unique case ({push_o, pop_o})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (pop_o) rd_ptr_q <= rd_ptr_q + 1'b1; // wraps at power-of-two depth
    end
  end

  assign rd_ptr_o  = rd_ptr_q;
  assign wr_ptr_o  = rd_ptr_q + cnt_q[AW-1:0];
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C); // R2
  AST_SINGLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !fifo_en_i) |=> cnt_q == CW'(1)); // R3
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == '0 && !push_req_i) |=> (cnt_q == '0 && $stable(rd_ptr_q))); // R6
  AST_DROP_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_i && !ready_o && !pop_i) |=> ($stable(cnt_q) && $stable(rd_ptr_q))); // R7
  AST_PUSH_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && pop_o) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] TRIG_C  = CW'(TRIG);
  localparam logic [CW-1:0] TRIG_M1 = CW'(TRIG - 1);

  logic empty_q, full_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (push_i || pop_i) begin
        empty_q <= (cnt_nxt_i == '0);
        full_q  <= (cnt_nxt_i == DEPTH_C) || (!fifo_en_i && cnt_nxt_i != '0);
      end
      if (push_i && !pop_i && cnt_nxt_i == TRIG_C)      irq_q <= 1'b1;
      else if (pop_i && !push_i && cnt_nxt_i == TRIG_M1) irq_q <= 1'b0;
    end
  end

  assign empty_o = empty_q;
  assign full_o  = full_q;
  assign irq_o   = irq_q;

  AST_EMPTY_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_q == (cnt_i == '0)); // R4
  AST_FULL_AT_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == DEPTH_C) |-> full_q); // R5
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && cnt_i == TRIG_M1) |=> irq_q); // R9
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_i == TRIG_C) |=> !irq_q); // R9
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               push_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               brk_i,
  input  logic               pop_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic               ready_o,
  output logic               empty_o,
  output logic               full_o,
  output logic               rx_irq_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          push_acc, pop_acc;
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt, cnt_nxt;
  rx_entry_t     wr_entry, rd_entry;

  assign wr_entry = make_entry(brk_i, data_i); // break wins over data

  rxf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .fifo_en_i,
    .push_req_i (push_i | brk_i),
    .pop_i,
    .ready_o,
    .push_o     (push_acc),
    .pop_o      (pop_acc),
    .rd_ptr_o   (rd_ptr),
    .wr_ptr_o   (wr_ptr),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt)
  );

  rxf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i, .rst_ni,
    .we_i    (push_acc),
    .waddr_i (wr_ptr),
    .wdata_i (wr_entry),
    .raddr_i (rd_ptr),
    .rdata_o (rd_entry)
  );

  rxf_flags #(.DEPTH(DEPTH), .TRIG(TRIG), .CW(CW)) u_flags (
    .clk_i, .rst_ni, .fifo_en_i,
    .push_i    (push_acc),
    .pop_i     (pop_acc),
    .cnt_i     (cnt),
    .cnt_nxt_i (cnt_nxt),
    .empty_o,
    .full_o,
    .irq_o     (rx_irq_o)
  );

  assign rd_data_o = rd_entry;

  AST_BRK_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && push_acc) |-> (wr_entry == rx_entry_t'(1 << BRK_BIT))); // R8
endmodule

// File: tb/uart_rx_fifo_tb.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb_top;
  localparam int DEPTH = 16;
  localparam int TRIG  = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fifo_en, push, brk, pop;
  logic [7:0]  data;
  logic [10:0] rd_data;
  logic        ready, empty, full, irq;

  int total = 0;
  int bad   = 0;
  int q[$];
  bit m_empty = 1, m_full = 0, m_irq = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_fifo #(.DEPTH(DEPTH), .TRIG(TRIG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .push_i(push),
    .data_i(data), .brk_i(brk), .pop_i(pop), .rd_data_o(rd_data),
    .ready_o(ready), .empty_o(empty), .full_o(full), .rx_irq_o(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle, compare with the model, advance the model
  task automatic step(input bit p, input logic [7:0] d, input bit b, input bit pp, input bit en);
    int  cnt;
    bit  rdy, acc, epop;
    int  ent;
    push = p; data = d; brk = b; pop = pp; fifo_en = en;
    #1;
    cnt = q.size();
    rdy = en ? (cnt < DEPTH) : (cnt == 0);
    check(en ? "R2" : "R3", "ready", int'(ready), int'(rdy));
    check("R4", "empty", int'(empty), int'(m_empty));
    check("R5", "full", int'(full), int'(m_full));
    check("R9", "irq", int'(irq), int'(m_irq));
    if (cnt > 0) check("R2", "head", int'(rd_data), q[0]);
    acc  = (p || b) && rdy;
    epop = pp && (cnt > 0);
    ent  = b ? 'h400 : int'(d);
    if (epop) void'(q.pop_front());
    if (acc) q.push_back(ent);
    if (acc || epop) begin
      m_empty = (q.size() == 0);
      m_full  = (q.size() == DEPTH) || (!en && q.size() != 0);
    end
    if (acc && !epop && q.size() == TRIG) m_irq = 1;
    else if (epop && !acc && q.size() == TRIG - 1) m_irq = 0;
    @(posedge clk);
    #1;
    push = 0; brk = 0; pop = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] snap;
    int lfsr;
    rst_n = 0; push = 0; brk = 0; pop = 0; data = 0; fifo_en = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "empty at reset", int'(empty), 1);
    check("R1", "full at reset", int'(full), 0);
    check("R1", "irq at reset", int'(irq), 0);
    check("R1", "ready at reset", int'(ready), 1);
    check("R1", "data at reset", int'(rd_data), 0);
    rst_n = 1;
    @(posedge clk); #1;

    // single-character mode
    step(1, 8'h41, 0, 0, 0);
    step(1, 8'h42, 0, 0, 0);                  // R7 dropped
    #1 check("R7", "head after dropped push", int'(rd_data), 'h41);
    check("R3", "single mode full", int'(full), 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    snap = rd_data;
    step(0, 0, 0, 1, 1);                      // R6 pop on empty
    check("R6", "data stable on empty pop", int'(rd_data), int'(snap));
    check("R6", "still empty", int'(empty), 1);

    // full-depth mode, overfill
    for (int i = 0; i < DEPTH + 1; i++) step(1, 8'(i * 7 + 3), 0, 0, 1);
    check("R5", "full at depth", int'(full), 1);
    check("R7", "17th push dropped, ready low", int'(ready), 0);
    step(1, 8'hEE, 0, 1, 1);                  // push dropped, pop done
    step(1, 8'hDD, 0, 1, 1);                  // R10 both
    check("R10", "count kept, not full", int'(full), 0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 1);
    check("R4", "drained empty", int'(empty), 1);

    // break entries
    step(0, 0, 1, 0, 1);
    #1 check("R8", "break entry", int'(rd_data), 'h400);
    step(1, 8'h55, 1, 0, 1);                  // break wins
    step(0, 0, 0, 1, 1);
    #1 check("R8", "second entry is break only", int'(rd_data), 'h400);
    step(0, 0, 0, 1, 1);
    check("R9", "irq cleared on drain", int'(irq), 0);

    // interrupt level
    step(1, 8'h10, 0, 0, 1);
    check("R9", "irq after first push", int'(irq), 1);
    step(1, 8'h11, 0, 0, 1);
    step(0, 0, 0, 1, 1);
    check("R9", "irq held at count 1", int'(irq), 1);
    step(0, 0, 0, 1, 1);
    check("R9", "irq cleared at 0", int'(irq), 0);

    // long mixed traffic, pointer wraps
    lfsr = 32'h1ACE;
    for (int i = 0; i < 600; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step(lfsr[0], 8'(lfsr >> 4), (lfsr[7:3] == 0), lfsr[1] & lfsr[2] | lfsr[9], lfsr[14:12] != 0);
    end
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 1);
    check("R11", "empty after wrap traffic", int'(empty), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule